// File: doc/BRIEF.md
# Tagged Add Subtract Unit

This unit adds or subtracts two 32-bit tagged integers. The two least significant bits of each operand hold a type tag, and arithmetic is only legal when both tags are zero. The unit raises a trap for an operand that carries a nonzero tag. It also raises a trap when the signed arithmetic overflows. When an operation completes without a trap, the unit writes new negative, zero, overflow and carry condition codes. A trapping operation leaves the held condition codes exactly as they were.

An operation is presented on one cycle with a valid strobe. Its outcome appears on the registered outputs on the next cycle: the result, the trap indication, the condition-code write enable and the held condition codes. The asynchronous reset is released synchronously inside the block, so the unit accepts operations two cycles after the reset input rises.

Top module: `tagalu_unit`

## Requirements
- R1: When a valid operation has bit 0 or bit 1 of either operand set, out_trap is 1 in the following cycle, for add and for subtract.
- R2: An add (in_sub = 0) with clean tags traps when both operands have the same bit 31 and the 32-bit sum has a different bit 31.
- R3: A subtract (in_sub = 1) with clean tags traps when the operands differ in bit 31 and the 32-bit difference differs from in_a in bit 31.
- R4: out_flags_we is 1 in the cycle after a valid operation that does not trap, and 0 otherwise. The condition-code outputs change only in a cycle where out_flags_we is 1.
- R5: After a non-trapping add, out_c is 1 exactly when the unsigned 32-bit sum is less than in_a.
- R6: After a non-trapping subtract, out_c is 1 exactly when in_a is unsigned-less-than in_b.
- R7: After a non-trapping operation, out_n equals bit 31 of the result and out_z is 1 exactly when the result is zero.
- R8: After a non-trapping operation, out_v is 0.
- R9: out_result carries the sum or difference of every valid operation in the following cycle, even when that operation traps.
- R10: A cycle without in_valid produces out_trap = 0 and out_flags_we = 0 in the next cycle, and leaves out_result and the condition codes unchanged, whatever the operand inputs are.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_sub | input | 1 | 0 = add, 1 = subtract (in_a - in_b) |
| in_a | input | 32 | First tagged operand |
| in_b | input | 32 | Second tagged operand |
| out_result | output | 32 | Registered sum or difference |
| out_n | output | 1 | Held negative flag |
| out_z | output | 1 | Held zero flag |
| out_v | output | 1 | Held overflow flag |
| out_c | output | 1 | Held carry / borrow flag |
| out_flags_we | output | 1 | Condition codes were written this cycle |
| out_trap | output | 1 | Tag-overflow trap for the previous operation |

## Verification
The hardest behaviour to show is that a trap suppresses the condition codes. This can only be seen at the ports when the held flags differ from the flags the trapping operation would have produced. Each trap scenario therefore first runs a clean operation that leaves a distinct flag pattern. It then issues a trapping operand pair whose result would give a different pattern, and checks that the old flags survive while out_result still shows the new value. Overflow traps with clean tags need operands at the signed boundaries, such as 0x7FFFFFFC plus 4 and 0x80000000 minus 4.

// File: rtl/tagalu_pkg.sv
package tagalu_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccodes_t;
endpackage

// File: rtl/tagalu_rst_sync.sv
module tagalu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/tagalu_tag_check.sv
module tagalu_tag_check #(
  parameter int WIDTH    = 32,
  parameter int TAG_BITS = 2
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic             tag_err
);
  generate
    if (TAG_BITS == 0) begin : g_untagged
      assign tag_err = 1'b0;
    end else begin : g_tagged
      logic [TAG_BITS-1:0] merged;
      assign merged  = opnd_a[TAG_BITS-1:0] | opnd_b[TAG_BITS-1:0];
      assign tag_err = |merged;
    end
  endgenerate
endmodule

// File: rtl/tagalu_addsub.sv
module tagalu_addsub
  import tagalu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  op_e              op,
  output logic [WIDTH-1:0] sum,
  output logic             carry,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic             is_sub;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   wide;

  always_comb begin
    is_sub = (op == OP_SUB);
    b_eff  = is_sub ? ~opnd_b : opnd_b;
    wide   = {1'b0, opnd_a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, is_sub};
    sum    = wide[WIDTH-1:0];
    // carry-out for add, inverted carry-out (borrow) for subtract
    carry  = is_sub ? ~wide[WIDTH] : wide[WIDTH];
    // signed overflow: effective operands agree in sign, sum does not
    ovf    = (opnd_a[MSB] == b_eff[MSB]) && (sum[MSB] != opnd_a[MSB]);
  end
endmodule

// File: rtl/tagalu_flags.sv
module tagalu_flags
  import tagalu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] sum,
  input  logic             carry,
  input  logic             ovf,
  output ccodes_t          cc
);
  always_comb begin
    cc.n = sum[WIDTH-1];
    cc.z = (sum == '0);
    cc.v = ovf;
    cc.c = carry;
  end
endmodule

// File: rtl/tagalu_unit.sv
module tagalu_unit
  import tagalu_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int TAG_BITS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sub,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic [WIDTH-1:0] out_result,
  output logic             out_n,
  output logic             out_z,
  output logic             out_v,
  output logic             out_c,
  output logic             out_flags_we,
  output logic             out_trap
);
  logic             rst_n_sync;
  op_e              op;
  logic             tag_err;
  logic [WIDTH-1:0] sum;
  logic             carry;
  logic             ovf;
  ccodes_t          cc_new;

  logic [WIDTH-1:0] res_d, res_q;
  ccodes_t          cc_d, cc_q;
  logic             trap_d, trap_q;
  logic             we_d, we_q;
  logic             take_trap;

  tagalu_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_n_sync)
  );

  assign op = in_sub ? OP_SUB : OP_ADD;

  tagalu_tag_check #(.WIDTH(WIDTH), .TAG_BITS(TAG_BITS)) u_tag (
    .opnd_a (in_a),
    .opnd_b (in_b),
    .tag_err(tag_err)
  );

  tagalu_addsub #(.WIDTH(WIDTH)) u_arith (
    .opnd_a(in_a),
    .opnd_b(in_b),
    .op    (op),
    .sum   (sum),
    .carry (carry),
    .ovf   (ovf)
  );

  tagalu_flags #(.WIDTH(WIDTH)) u_flags (
    .sum  (sum),
    .carry(carry),
    .ovf  (ovf),
    .cc   (cc_new)
  );

  // next-state
  always_comb begin
    take_trap = tag_err | ovf;
    res_d     = res_q;
    cc_d      = cc_q;
    trap_d    = 1'b0;
    we_d      = 1'b0;
    if (in_valid) begin
      res_d  = sum;
      trap_d = take_trap;
      we_d   = ~take_trap;
      if (!take_trap) cc_d = cc_new;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      res_q  <= '0;
      cc_q   <= '0;
      trap_q <= 1'b0;
      we_q   <= 1'b0;
    end else begin
      res_q  <= res_d;
      cc_q   <= cc_d;
      trap_q <= trap_d;
      we_q   <= we_d;
    end
  end

  assign out_result   = res_q;
  assign out_n        = cc_q.n;
  assign out_z        = cc_q.z;
  assign out_v        = cc_q.v;
  assign out_c        = cc_q.c;
  assign out_flags_we = we_q;
  assign out_trap     = trap_q;
endmodule

// File: rtl/tagalu_unit_chk.sv
module tagalu_unit_chk #(
  parameter int WIDTH    = 32,
  parameter int TAG_BITS = 2
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             in_valid,
  input logic             in_sub,
  input logic [WIDTH-1:0] in_a,
  input logic [WIDTH-1:0] in_b,
  input logic [WIDTH-1:0] out_result,
  input logic             out_n,
  input logic             out_z,
  input logic             out_v,
  input logic             out_c,
  input logic             out_flags_we,
  input logic             out_trap
);
  localparam int MSB = WIDTH - 1;
  localparam logic [WIDTH-1:0] TAG_MASK = WIDTH'((64'd1 << TAG_BITS) - 64'd1);

  logic [WIDTH-1:0] add_w, sub_w;
  logic             tags_clean;
  logic [3:0]       flags;

  assign add_w      = in_a + in_b;
  assign sub_w      = in_a - in_b;
  assign tags_clean = ((in_a | in_b) & TAG_MASK) == '0;
  assign flags      = {out_n, out_z, out_v, out_c};

  assert_tag_trap_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && !tags_clean) |=> out_trap);

  assert_add_ovf_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && !in_sub && in_a[MSB] == in_b[MSB] && add_w[MSB] != in_a[MSB]) |=> out_trap);

  assert_sub_ovf_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && in_sub && in_a[MSB] != in_b[MSB] && sub_w[MSB] != in_a[MSB]) |=> out_trap);

  assert_trap_no_write_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    !(out_trap && out_flags_we));

  assert_flags_hold_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    !out_flags_we |-> flags == $past(flags));

  assert_add_carry_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && !in_sub) |=> (out_flags_we |-> out_c == (out_result < $past(in_a))));

  assert_sub_borrow_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && in_sub) |=> (out_flags_we |-> out_c == ($past(in_a) < $past(in_b))));

  assert_nz_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    out_flags_we |-> (out_n == out_result[MSB] && out_z == (out_result == '0)));

  assert_no_v_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    out_flags_we |-> !out_v);

  assert_result_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid |=> out_result == $past(in_sub ? sub_w : add_w));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> (!out_trap && !out_flags_we && $stable(out_result)));
endmodule

bind tagalu_unit tagalu_unit_chk #(.WIDTH(WIDTH), .TAG_BITS(TAG_BITS)) u_chk (
  .clk         (clk),
  .rst_ok      (rst_n_sync),
  .in_valid    (in_valid),
  .in_sub      (in_sub),
  .in_a        (in_a),
  .in_b        (in_b),
  .out_result  (out_result),
  .out_n       (out_n),
  .out_z       (out_z),
  .out_v       (out_v),
  .out_c       (out_c),
  .out_flags_we(out_flags_we),
  .out_trap    (out_trap)
);

// File: tb/tagalu_unit_bench.sv
module tagalu_unit_bench;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_sub;
  logic [31:0] in_a, in_b;
  logic [31:0] out_result;
  logic        out_n, out_z, out_v, out_c, out_flags_we, out_trap;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // bench model of the held condition codes
  logic m_n, m_z, m_v, m_c;

  tagalu_unit u_tagalu_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sub(in_sub),
    .in_a(in_a), .in_b(in_b), .out_result(out_result),
    .out_n(out_n), .out_z(out_z), .out_v(out_v), .out_c(out_c),
    .out_flags_we(out_flags_we), .out_trap(out_trap)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // one operation driven at a negedge, outcome checked at the next negedge
  task automatic do_op(input string req, input logic sub,
                       input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    logic tag, v, c, trap;
    in_valid = 1'b1; in_sub = sub; in_a = a; in_b = b;
    r    = sub ? a - b : a + b;
    tag  = ((a | b) & 32'h3) != 0;
    v    = sub ? (a[31] != b[31] && r[31] != a[31])
               : (a[31] == b[31] && r[31] != a[31]);
    c    = sub ? (a < b) : ({1'b0, a} + {1'b0, b} > 33'hFFFF_FFFF);
    trap = tag | v;
    if (!trap) begin
      m_n = r[31]; m_z = (r == 0); m_v = 1'b0; m_c = c;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(req,  "trap",     {31'd0, out_trap},     {31'd0, trap});
    check("R4", "flags_we", {31'd0, out_flags_we}, {31'd0, ~trap});
    check("R9", "result",   out_result,            r);
    check("R7", "n/z",      {30'd0, out_n, out_z}, {30'd0, m_n, m_z});
    check("R8", "v",        {31'd0, out_v},        {31'd0, m_v});
    check(sub ? "R6" : "R5", "c", {31'd0, out_c},  {31'd0, m_c});
  endtask

  task automatic test_reset_R11();
    rst_n = 1'b0; in_valid = 1'b0; in_sub = 1'b0; in_a = '0; in_b = '0;
    m_n = 0; m_z = 0; m_v = 0; m_c = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11", "reset outputs",
          {out_result[27:0], out_n, out_z, out_v, out_c},
          32'd0);
    check("R11", "reset trap/we", {30'd0, out_trap, out_flags_we}, 32'd0);
  endtask

  task automatic test_add_plain();
    do_op("R5", 1'b0, 32'h0000_0010, 32'h0000_0024);   // small sum
    do_op("R7", 1'b0, 32'h8000_0000, 32'h0000_0004);   // negative result
    do_op("R5", 1'b0, 32'hFFFF_FFFC, 32'h0000_0004);   // zero with carry
    do_op("R5", 1'b0, 32'hC000_0000, 32'hC000_0000);   // carry, no overflow
  endtask

  task automatic test_sub_plain();
    do_op("R6", 1'b1, 32'h0000_0100, 32'h0000_0040);
    do_op("R6", 1'b1, 32'h0000_0004, 32'h0000_0008);   // borrow
    do_op("R7", 1'b1, 32'h1234_5678, 32'h1234_5678);   // zero
    do_op("R6", 1'b1, 32'h8000_0000, 32'hFFFF_FFFC);   // borrow, negative
  endtask

  // each trap is preceded by a clean op leaving a distinct flag pattern
  task automatic test_tag_traps_R1();
    do_op("R4", 1'b0, 32'h0000_0004, 32'h0000_0004);   // n=0 z=0 c=0
    do_op("R1", 1'b0, 32'hFFFF_FFFD, 32'h0000_0003);   // would be zero + carry
    do_op("R1", 1'b1, 32'h0000_0008, 32'hFFFF_FFFE);   // tag on b only
    do_op("R4", 1'b1, 32'h0000_0000, 32'h0000_0004);   // n=1 c=1
    do_op("R1", 1'b1, 32'h0000_0011, 32'h0000_0010);   // tag on a, would clear n/c
    do_op("R1", 1'b0, 32'h0000_0002, 32'h0000_0000);   // bit 1 on a
  endtask

  task automatic test_add_overflow_R2();
    do_op("R4", 1'b0, 32'h0000_0000, 32'h0000_0000);   // z=1
    do_op("R2", 1'b0, 32'h7FFF_FFFC, 32'h0000_0004);
    do_op("R2", 1'b0, 32'h8000_0000, 32'h8000_0000);   // would be zero
    do_op("R2", 1'b0, 32'h8000_0004, 32'hC000_0000);
  endtask

  task automatic test_sub_overflow_R3();
    do_op("R4", 1'b0, 32'h0000_0008, 32'hFFFF_FFF0);   // n=1
    do_op("R3", 1'b1, 32'h8000_0000, 32'h0000_0004);
    do_op("R3", 1'b1, 32'h7FFF_FFFC, 32'hFFFF_FFFC);
    do_op("R3", 1'b1, 32'h0000_0000, 32'h8000_0000);
  endtask

  task automatic test_idle_R10();
    logic [31:0] r0;
    logic [3:0]  f0;
    do_op("R5", 1'b0, 32'h0000_1000, 32'h0000_2000);
    r0 = out_result;
    f0 = {out_n, out_z, out_v, out_c};
    in_a = 32'h7FFF_FFFF; in_b = 32'h0000_0001; in_sub = 1'b1;  // ignored
    repeat (3) begin
      @(negedge clk);
      check("R10", "idle trap/we", {30'd0, out_trap, out_flags_we}, 32'd0);
      check("R10", "idle result",  out_result, r0);
      check("R10", "idle flags",   {28'd0, out_n, out_z, out_v, out_c}, {28'd0, f0});
    end
  endtask

  task automatic test_back_to_back();
    do_op("R9", 1'b0, 32'h0000_0040, 32'h0000_0040);
    do_op("R9", 1'b1, 32'h0000_0040, 32'h0000_0080);
    do_op("R2", 1'b0, 32'h7000_0000, 32'h7000_0000);
    do_op("R9", 1'b1, 32'hFFFF_FFF0, 32'hFFFF_FFF0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    test_reset_R11();
    test_add_plain();
    test_sub_plain();
    test_tag_traps_R1();
    test_add_overflow_R2();
    test_sub_overflow_R3();
    test_idle_R10();
    test_back_to_back();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule